// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which of a serial controller's five interrupt conditions the host should service, and reports it. It holds a four-bit enable mask and a FIFO-mode flag. It samples five status levels from the surrounding controller: receiver line error, receive data ready, character timeout, transmitter holding register empty and modem-line change. From these it forms an identification byte. The low nibble of that byte carries a fixed code for the most urgent enabled condition, or a "nothing pending" marker. The two top bits show whether FIFO mode is on.

The host reaches the block through a byte-wide strobe interface. It writes the enable mask at one address. At a second address it reads the identification byte, and a write to that address sets or clears the FIFO-mode flag. An active-high interrupt line is asserted whenever an enabled condition is pending. The transmit-empty condition is the only one held inside the block. It is armed on a fresh rising edge of the empty status, and it is acknowledged when the host reads an identification byte that carries its code.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable mask is 0 and FIFO mode is off. The identification byte (address 2) reads 0x01, and `irq_o` is 0.
- R2: A write to address 1 loads `wdata[3:0]` into the enable mask. Address 1 reads back `{4'b0000, mask}`, so bits 7:4 of the write are ignored. Mask bit 0 enables receive data, bit 1 enables transmit empty, bit 2 enables line error, and bit 3 enables modem change.
- R3: When exactly one enabled condition is pending, identification bits 3:0 read 0x6 for line error, 0x4 for receive data, 0xC for character timeout, 0x2 for transmit empty and 0x0 for modem change.
- R4: With several enabled conditions pending, the code shown is the highest in this order: line error, then receive data or timeout, then transmit empty, then modem change.
- R5: Character timeout is gated by mask bit 0. When receive data and timeout are both pending, code 0x4 wins.
- R6: Identification bit 0 reads 0 when an enabled condition is pending and 1 when none is. A pending condition whose mask bit is 0 has no effect on the byte or on `irq_o`.
- R7: Identification bits 7:6 read 11 when FIFO mode is on and 00 when it is off. Bit 0 of a write to address 2 sets the mode. Bits 5:4 always read 0.
- R8: A read strobe at address 2 that returns code 0x2 clears the pending transmit-empty condition. A read that returns any other code leaves it pending.
- R9: The transmit-empty condition becomes pending on a rising edge of `tx_empty_i`. It drops whenever `tx_empty_i` is low, and it stays pending while `tx_empty_i` stays high until R8 clears it.
- R10: Status inputs are registered once, so their effect appears on the byte one clock after they are sampled. `irq_o` always equals the inverse of identification bit 0. Addresses 0 and 3 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (only matters for the R8 acknowledge) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on `addr` |
| lsr_err_i | input | 1 | Receiver line error level |
| rx_avail_i | input | 1 | Receive data ready level |
| rx_tmo_i | input | 1 | Character timeout level |
| tx_empty_i | input | 1 | Transmit holding register empty level |
| modem_chg_i | input | 1 | Modem-line change level |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that the host never asserts `wr_en` and `rd_en` in the same cycle, and that strobes are sampled only outside reset. The random stimulus draws one access type per cycle to honour the first assumption, and it drives every input low while reset is held. The status inputs are treated as free levels, so `tx_empty_i` toggles at random to create fresh rising edges. Reads at address 2 fall on random cycles, so acknowledges are tested both when the transmit-empty code is on top and when a higher code masks it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned EN_W = 4;

    // Enable mask bit positions
    localparam int unsigned EN_RXA  = 0;
    localparam int unsigned EN_THRE = 1;
    localparam int unsigned EN_LSR  = 2;
    localparam int unsigned EN_MSC  = 3;

    // Identification nibble codes
    localparam logic [3:0] CODE_LSR  = 4'h6;
    localparam logic [3:0] CODE_RXA  = 4'h4;
    localparam logic [3:0] CODE_CTO  = 4'hC;
    localparam logic [3:0] CODE_THRE = 4'h2;
    localparam logic [3:0] CODE_MSC  = 4'h0;
    localparam logic [3:0] CODE_NONE = 4'h1;

    typedef struct packed {
        logic lsr;
        logic rxa;
        logic cto;
        logic thre;
        logic msc;
    } irq_src_t;

    function automatic logic [3:0] pick_code(irq_src_t s, logic [EN_W-1:0] en);
        logic [3:0] c;
        if (s.lsr && en[EN_LSR])        c = CODE_LSR;
        else if (s.rxa && en[EN_RXA])   c = CODE_RXA;
        else if (s.cto && en[EN_RXA])   c = CODE_CTO;
        else if (s.thre && en[EN_THRE]) c = CODE_THRE;
        else if (s.msc && en[EN_MSC])   c = CODE_MSC;
        else                            c = CODE_NONE;
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_IEN  = 1,
    parameter int unsigned ADDR_FCTL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [EN_W-1:0]   ien_q,
    output logic              fifo_en_q
);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:EN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q     <= '0;
            fifo_en_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADDR_IEN))  ien_q     <= wdata[EN_W-1:0];
            if (addr == ADDR_W'(ADDR_FCTL)) fifo_en_q <= wdata[0];
        end
    end

    assert_ien_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(ADDR_IEN)) |=> (ien_q == $past(wdata[EN_W-1:0])));

    assert_fifo_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(ADDR_FCTL)) |=> (fifo_en_q == $past(wdata[0])));

endmodule

// File: rtl/uart_irq_srcs.sv
module uart_irq_srcs
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lsr_err_i,
    input  logic     rx_avail_i,
    input  logic     rx_tmo_i,
    input  logic     tx_empty_i,
    input  logic     modem_chg_i,
    input  logic     thre_clr,
    output irq_src_t src_q
);

    logic tx_empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q      <= '0;
            tx_empty_q <= 1'b0;
        end else begin
            src_q.lsr  <= lsr_err_i;
            src_q.rxa  <= rx_avail_i;
            src_q.cto  <= rx_tmo_i;
            src_q.msc  <= modem_chg_i;
            src_q.thre <= tx_empty_i & (~tx_empty_q | (src_q.thre & ~thre_clr));
            tx_empty_q <= tx_empty_i;
        end
    end

    assert_thre_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (thre_clr && tx_empty_q) |=> !src_q.thre);

    assert_thre_drop_R9: assert property (@(posedge clk) disable iff (rst)
        !tx_empty_i |=> !src_q.thre);

    assert_thre_edge_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_empty_i && !tx_empty_q) |=> src_q.thre);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  irq_src_t          src,
    input  logic [EN_W-1:0]   ien,
    input  logic              fifo_en,
    output logic [DATA_W-1:0] ident
);

    localparam int unsigned PAD_W = DATA_W - 6;

    logic [3:0] code;

    always_comb begin
        code  = pick_code(src, ien);
        ident = {{2{fifo_en}}, {PAD_W{1'b0}}, code};
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ADDR_IEN   = 1,
    parameter int unsigned ADDR_IDENT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              lsr_err_i,
    input  logic              rx_avail_i,
    input  logic              rx_tmo_i,
    input  logic              tx_empty_i,
    input  logic              modem_chg_i,
    output logic              irq_o
);

    logic [EN_W-1:0]   ien_q;
    logic              fifo_en_q;
    irq_src_t          src_q;
    logic [DATA_W-1:0] ident;
    logic              thre_clr;

    uart_irq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ADDR_IEN(ADDR_IEN), .ADDR_FCTL(ADDR_IDENT)
    ) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ien_q(ien_q), .fifo_en_q(fifo_en_q)
    );

    uart_irq_srcs srcs_i (
        .clk(clk), .rst(rst),
        .lsr_err_i(lsr_err_i), .rx_avail_i(rx_avail_i), .rx_tmo_i(rx_tmo_i),
        .tx_empty_i(tx_empty_i), .modem_chg_i(modem_chg_i),
        .thre_clr(thre_clr), .src_q(src_q)
    );

    uart_irq_prio #(.DATA_W(DATA_W)) prio_i (
        .src(src_q), .ien(ien_q), .fifo_en(fifo_en_q), .ident(ident)
    );

    always_comb begin
        thre_clr = rd_en && (addr == ADDR_W'(ADDR_IDENT)) && (ident[3:0] == CODE_THRE);
        irq_o    = ~ident[0];
        if (addr == ADDR_W'(ADDR_IEN))        rdata = DATA_W'(ien_q);
        else if (addr == ADDR_W'(ADDR_IDENT)) rdata = ident;
        else                                  rdata = '0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ident == DATA_W'(8'h01) && !irq_o));

    assert_lsr_top_R4: assert property (@(posedge clk) disable iff (rst)
        (src_q.lsr && ien_q[EN_LSR]) |-> (ident[3:0] == CODE_LSR));

    assert_rxa_over_cto_R5: assert property (@(posedge clk) disable iff (rst)
        (src_q.rxa && ien_q[EN_RXA] && !(src_q.lsr && ien_q[EN_LSR]))
            |-> (ident[3:0] == CODE_RXA));

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((src_q.lsr && ien_q[EN_LSR]) || ((src_q.rxa || src_q.cto) && ien_q[EN_RXA])
                   || (src_q.thre && ien_q[EN_THRE]) || (src_q.msc && ien_q[EN_MSC])));

    assert_fifo_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (ident[7:6] == {2{fifo_en_q}}) && (ident[5:4] == 2'b00));

endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 4000;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic       lsr_err_i, rx_avail_i, rx_tmo_i, tx_empty_i, modem_chg_i;
    logic       irq_o;

    int n_vec = 0;
    int n_bad = 0;

    // model state
    logic [3:0] m_ien;
    logic       m_fifo, m_lsr, m_rxa, m_cto, m_thr, m_msc, m_txq;
    logic [7:0] last_rdata;
    logic       last_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .lsr_err_i(lsr_err_i), .rx_avail_i(rx_avail_i), .rx_tmo_i(rx_tmo_i),
        .tx_empty_i(tx_empty_i), .modem_chg_i(modem_chg_i), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_ident();
        logic [3:0] c;
        if (m_lsr && m_ien[2])      c = 4'h6;
        else if (m_rxa && m_ien[0]) c = 4'h4;
        else if (m_cto && m_ien[0]) c = 4'hC;
        else if (m_thr && m_ien[1]) c = 4'h2;
        else if (m_msc && m_ien[3]) c = 4'h0;
        else                        c = 4'h1;
        return {m_fifo, m_fifo, 2'b00, c};
    endfunction

    function automatic logic [7:0] exp_rdata(logic [1:0] a);
        if (a == 2'd1) return {4'b0000, m_ien};
        if (a == 2'd2) return exp_ident();
        return 8'h00;
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // s = {lsr, rxa, cto, tx_empty, msc}; called just after a falling edge
    task automatic cycle(logic w, logic r, logic [1:0] a, logic [7:0] d,
                         logic [4:0] s, string tag);
        logic [7:0] id;
        logic       clr;
        wr_en = w; rd_en = r; addr = a; wdata = d;
        {lsr_err_i, rx_avail_i, rx_tmo_i, tx_empty_i, modem_chg_i} = s;
        #1;
        last_rdata = rdata;
        last_irq   = irq_o;
        id = exp_ident();
        check8({tag, " rdata (R10)"}, rdata, exp_rdata(a));
        check8("R10 irq", {7'd0, irq_o}, {7'd0, ~id[0]});
        clr = r && (a == 2'd2) && (id[3:0] == 4'h2);
        m_thr = s[1] & (~m_txq | (m_thr & ~clr));
        m_txq = s[1];
        m_lsr = s[4]; m_rxa = s[3]; m_cto = s[2]; m_msc = s[0];
        if (w && a == 2'd1) m_ien  = d[3:0];
        if (w && a == 2'd2) m_fifo = d[0];
        @(negedge clk);
    endtask

    task automatic expect_ident(logic [4:0] s, logic [7:0] exp, string tag);
        cycle(1'b0, 1'b1, 2'd2, 8'h00, s, tag);
        check8(tag, last_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        {lsr_err_i, rx_avail_i, rx_tmo_i, tx_empty_i, modem_chg_i} = '0;
        m_ien = 0; m_fifo = 0; m_lsr = 0; m_rxa = 0; m_cto = 0;
        m_thr = 0; m_msc = 0; m_txq = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_ident(5'b00000, 8'h01, "R1 ident after reset");
        check8("R1 irq after reset", {7'd0, last_irq}, 8'h00);
        cycle(0, 1, 2'd1, 8'h00, 5'b00000, "R1 mask");
        check8("R1 mask after reset", last_rdata, 8'h00);

        // R2 mask write, high bits ignored
        cycle(1, 0, 2'd1, 8'hFF, 5'b00000, "R2 write");
        cycle(0, 1, 2'd1, 8'h00, 5'b00000, "R2 read");
        check8("R2 mask readback", last_rdata, 8'h0F);
        cycle(0, 1, 2'd0, 8'h00, 5'b00000, "R10 addr0");
        check8("R10 addr0 reads zero", last_rdata, 8'h00);

        // R3 modem change alone
        cycle(0, 0, 2'd0, 8'h00, 5'b00001, "R3 setup");
        expect_ident(5'b00001, 8'h00, "R3 modem code");
        check8("R6 irq pending", {7'd0, last_irq}, 8'h01);
        // R4 transmit empty over modem; R8 read acknowledges it
        cycle(0, 0, 2'd0, 8'h00, 5'b00011, "R9 edge");
        expect_ident(5'b00011, 8'h02, "R4 thre over modem");
        expect_ident(5'b00011, 8'h00, "R8 thre acknowledged");
        // R4/R5 receive-side ordering
        cycle(0, 0, 2'd0, 8'h00, 5'b11100, "R4 setup");
        expect_ident(5'b01100, 8'h06, "R4 line error top");
        expect_ident(5'b00100, 8'h04, "R5 rx over timeout");
        expect_ident(5'b00000, 8'h0C, "R3 timeout code");
        // R6 masked source has no effect
        cycle(1, 0, 2'd1, 8'h02, 5'b01000, "R6 mask");
        expect_ident(5'b01000, 8'h01, "R6 masked rx ignored");
        check8("R6 irq idle", {7'd0, last_irq}, 8'h00);
        // R7 FIFO mode bits
        cycle(1, 0, 2'd2, 8'h01, 5'b00000, "R7 fifo on");
        expect_ident(5'b00000, 8'hC1, "R7 fifo bits");
        // R8 negative: read showing line error keeps thre pending
        cycle(1, 0, 2'd1, 8'h06, 5'b00010, "R8 setup");
        cycle(0, 0, 2'd0, 8'h00, 5'b10010, "R8 edge+lsr");
        expect_ident(5'b00010, 8'hC6, "R8 lsr read");
        expect_ident(5'b00010, 8'hC2, "R8 thre still pending");
        expect_ident(5'b00010, 8'hC1, "R8 acked");
        // R9 drop on low, re-arm on fresh edge
        cycle(0, 0, 2'd0, 8'h00, 5'b00000, "R9 low");
        expect_ident(5'b00010, 8'hC1, "R9 dropped while low");
        expect_ident(5'b00010, 8'hC2, "R9 rearmed by edge");
        cycle(1, 0, 2'd2, 8'h00, 5'b00000, "R7 fifo off");
        expect_ident(5'b00000, 8'h01, "R7 fifo off bits");

        // Random phase
        void'($urandom(32'd1234));
        for (int i = 0; i < N_RAND; i++) begin
            logic [3:0] op;
            logic [4:0] s;
            op = 4'($urandom_range(0, 15));
            s  = 5'($urandom);
            if (($urandom & 3) != 0) s[4] = 1'b0;
            if (op < 2)      cycle(1, 0, 2'd1, 8'($urandom), s, "R2 rand");
            else if (op < 3) cycle(1, 0, 2'd2, 8'($urandom), s, "R7 rand");
            else if (op < 9) cycle(0, 1, 2'($urandom), 8'h00, s, "R8 rand");
            else             cycle(0, 0, 2'($urandom), 8'h00, s, "R4 rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule